// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block is a clock-sampled model of the control side of an asynchronous DRAM. A fast system clock samples the active-low strobes `ras_n`, `cas_n`, `we_n` and `oe_n`, and a state machine sorts every strobe cycle into one of these kinds:

- normal read
- early write
- read-modify-write
- row-only refresh
- CAS-before-RAS refresh
- test-mode entry
- illegal

The cells are a small register file inside the block. The block drives a data output bus and its enable. It also gates every access on a power-up readiness condition: a start-up wait, followed by a minimum number of refresh cycles.

A test mode latches across cycles. While it is set, the low column bits are ignored. A write fills the whole group of cells that share the remaining address bits. A read compares the cells of that group and drives the same bit on every data line: all ones if the cells match, all zeros if they do not. Test reads take a few extra clocks.

The states of the machine are as follows:

- ST_IDLE: RAS is high.
- ST_ROW: the row is latched and CAS is still high.
- ST_ACCESS: the read access delay is counting.
- ST_READ: read data is presented.
- ST_RMW: a late write has been applied and the old data is still presented.
- ST_REFRESH: CAS was low when RAS fell.
- ST_HOLD: the column part of the cycle has ended or was ignored.
- ST_BAD: an illegal cycle.

The transitions are as follows:

- Any state returns to ST_IDLE when RAS rises.
- ST_IDLE goes to ST_ROW when RAS falls with CAS high, and to ST_REFRESH when RAS falls with CAS low.
- ST_ROW goes to ST_ACCESS when CAS falls with WE high and the block ready. It goes to ST_HOLD when CAS falls with WE low, or with the block not ready.
- ST_ACCESS goes to ST_READ when its count expires, and to ST_BAD when WE falls first.
- ST_READ goes to ST_RMW when WE falls.
- ST_ACCESS, ST_READ, ST_RMW and ST_BAD go to ST_HOLD when CAS rises.

Top module: `dramc_cycle_decoder`

## Requirements
- R1: During and right after reset, `ready`, `dq_oe`, `test_mode` and `err` are 0 and `cyc_kind` is 0 (none).
- R2: `ready` rises only once two things have happened. First, STARTUP_CYC clocks have passed since reset. Second, INIT_CYC refresh cycles (row-only or CAS-before-RAS) have completed after that. Refreshes that finish earlier are not counted. Once set, `ready` stays set.
- R3: While `ready` is 0, read and write cycles are ignored. No cell is written, `dq_oe` stays 0 and `cyc_kind` is unchanged.
- R4: In a normal read, `dq_oe` rises ACC_CYC clocks after the clock that sees CAS fall, provided OE is low. `dq_out` then carries the addressed cell and `cyc_kind` is 1. `dq_oe` drops at once when OE or CAS goes high.
- R5: If WE is low when CAS falls, `din` is written to the addressed cell, `dq_oe` stays 0 for the whole cycle (even with OE low) and `cyc_kind` is 2.
- R6: If WE falls after read data is presented, `din` is written to the cell and `cyc_kind` becomes 3. `dq_out` keeps presenting the old cell value while CAS and OE stay low.
- R7: A cycle in which RAS falls and rises with CAS high is a row-only refresh, and `cyc_kind` is 4. RAS falling with CAS low and WE high is a CAS-before-RAS refresh, and `cyc_kind` is 5.
- R8: RAS falling with CAS and WE both low while ready sets `test_mode` and sets `cyc_kind` to 6. `test_mode` stays set over later cycles.
- R9: A row-only refresh or a CAS-before-RAS refresh clears `test_mode`.
- R10: In test mode, a write ignores column bits 1:0 and writes `din` to all four cells whose row and upper column bits match the address.
- R11: In test mode, a read takes ACC_CYC+TEST_XTRA clocks. It drives every `dq_out` bit 1 when the four group cells are equal, and 0 when any of them differ.
- R12: If WE falls while the read access is still counting, `err` goes to 1, `cyc_kind` becomes 7, and `dq_out` carries the marker value 4'hA (enabled while CAS and OE are low). `err` clears once CAS or RAS rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-up reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (3) | Multiplexed row/column address |
| din | input | DW (4) | Write data |
| dq_out | output | DW (4) | Read data, test result or error marker |
| dq_oe | output | 1 | Data output enable (0 = high impedance) |
| ready | output | 1 | Initialization complete |
| test_mode | output | 1 | Parallel test mode latched |
| err | output | 1 | Illegal cycle in progress |
| cyc_kind | output | 3 | Last classified cycle kind (codes in R4 to R12) |

## Verification
A wrong state in the machine shows up as a `dq_oe` that rises a clock early or late, or as a wrong `cyc_kind` code on the clock after the deciding strobe edge. A missed test-mode latch changes the width of the next write. That error only becomes visible on a later read, so reads follow every write, both inside and outside the tested group. A faulty readiness count shows up as `ready` rising one refresh too early or too late, so it is sampled right after the seventh and eighth counted refreshes.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_ACCESS,
        ST_READ,
        ST_RMW,
        ST_REFRESH,
        ST_HOLD,
        ST_BAD
    } dramc_state_e;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_READ    = 3'd1,
        K_EWRITE  = 3'd2,
        K_RMW     = 3'd3,
        K_ROR     = 3'd4,
        K_CBR     = 3'd5,
        K_TEST    = 3'd6,
        K_ILLEGAL = 3'd7
    } dramc_kind_e;

endpackage

// File: rtl/dramc_init_tracker.sv
module dramc_init_tracker #(
    parameter int STARTUP_CYC = 50000,
    parameter int INIT_CYC    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_evt,
    output logic ready
);
    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam int IW = $clog2(INIT_CYC + 1);

    logic [SW-1:0] wait_cnt;
    logic [IW-1:0] ref_cnt;
    logic          wait_done;

    assign wait_done = (wait_cnt == SW'(STARTUP_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            ref_cnt  <= '0;
        end else begin
            if (!wait_done)
                wait_cnt <= wait_cnt + 1'b1;
            if (wait_done && refresh_evt && (ref_cnt != IW'(INIT_CYC)))
                ref_cnt <= ref_cnt + 1'b1;
        end
    end

    assign ready = wait_done && (ref_cnt == IW'(INIT_CYC));

endmodule

// File: rtl/dramc_cell_array.sv
module dramc_cell_array #(
    parameter int ROW_W = 2,
    parameter int COL_W = 3,
    parameter int DW    = 4,
    parameter int CMP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             wr_en,
    input  logic             wr_bcast,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_word,
    output logic             rd_match
);
    localparam int IXW   = ROW_W + COL_W;
    localparam int DEPTH = 1 << IXW;
    localparam int GRP   = 1 << CMP_W;
    localparam int BW    = IXW - CMP_W;

    logic [DW-1:0] mem [DEPTH];
    logic [BW-1:0] base;

    assign base = {row_i, col_i[COL_W-1:CMP_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            if (wr_bcast) begin
                for (int g = 0; g < GRP; g++)
                    mem[{base, CMP_W'(g)}] <= wdata;
            end else begin
                mem[{row_i, col_i}] <= wdata;
            end
        end
    end

    assign rd_word = mem[{row_i, col_i}];

    always_comb begin
        rd_match = 1'b1;
        for (int g = 1; g < GRP; g++)
            if (mem[{base, CMP_W'(g)}] != mem[{base, CMP_W'(0)}])
                rd_match = 1'b0;
    end

endmodule

// File: rtl/dramc_cycle_fsm.sv
module dramc_cycle_fsm
    import dramc_pkg::*;
#(
    parameter int          ROW_W     = 2,
    parameter int          COL_W     = 3,
    parameter int          AW        = 3,
    parameter int          DW        = 4,
    parameter int          ACC_CYC   = 4,
    parameter int          TEST_XTRA = 2,
    parameter logic [DW-1:0] BAD_MARK = 4'hA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic             ready,
    input  logic [DW-1:0]    rd_word,
    input  logic             rd_match,
    output logic [ROW_W-1:0] mem_row,
    output logic [COL_W-1:0] mem_col,
    output logic             wr_en,
    output logic             wr_bcast,
    output logic             refresh_evt,
    output logic             test_mode,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    output logic             err,
    output logic [2:0]       cyc_kind
);
    localparam int CW = $clog2(ACC_CYC + TEST_XTRA + 1);

    dramc_state_e st, st_n;
    dramc_kind_e  kind_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [CW-1:0]    acc_cnt;
    logic [DW-1:0]    rd_q;

    logic ras_lo_cas_lo, ror_evt, cbr_fall, wcbr_evt, cbr_evt;
    logic ew_evt, rmw_evt, rd_start, acc_done, bad_evt;

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:    if (!ras_n) st_n = cas_n ? ST_ROW : ST_REFRESH;
            ST_ROW: begin
                if (ras_n)       st_n = ST_IDLE;
                else if (!cas_n) st_n = (!ready || !we_n) ? ST_HOLD : ST_ACCESS;
            end
            ST_ACCESS: begin
                if (ras_n)                st_n = ST_IDLE;
                else if (cas_n)           st_n = ST_HOLD;
                else if (!we_n)           st_n = ST_BAD;
                else if (acc_cnt == '0)   st_n = ST_READ;
            end
            ST_READ: begin
                if (ras_n)       st_n = ST_IDLE;
                else if (cas_n)  st_n = ST_HOLD;
                else if (!we_n)  st_n = ST_RMW;
            end
            ST_RMW, ST_BAD: begin
                if (ras_n)       st_n = ST_IDLE;
                else if (cas_n)  st_n = ST_HOLD;
            end
            ST_REFRESH, ST_HOLD: if (ras_n) st_n = ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // strobe events
    assign ras_lo_cas_lo = !ras_n && !cas_n;
    assign cbr_fall = (st == ST_IDLE) && ras_lo_cas_lo;
    assign wcbr_evt = cbr_fall && !we_n && ready;
    assign cbr_evt  = cbr_fall && we_n;
    assign ror_evt  = (st == ST_ROW) && ras_n;
    assign ew_evt   = (st == ST_ROW) && ras_lo_cas_lo && !we_n && ready;
    assign rd_start = (st == ST_ROW) && ras_lo_cas_lo && we_n && ready;
    assign acc_done = (st == ST_ACCESS) && ras_lo_cas_lo && we_n && (acc_cnt == '0);
    assign bad_evt  = (st == ST_ACCESS) && ras_lo_cas_lo && !we_n;
    assign rmw_evt  = (st == ST_READ) && ras_lo_cas_lo && !we_n;

    // cycle datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q     <= '0;
            col_q     <= '0;
            acc_cnt   <= '0;
            rd_q      <= '0;
            test_mode <= 1'b0;
            kind_q    <= K_NONE;
        end else begin
            if ((st == ST_IDLE) && !ras_n)
                row_q <= addr[ROW_W-1:0];
            if (rd_start) begin
                col_q   <= addr[COL_W-1:0];
                acc_cnt <= test_mode ? CW'(ACC_CYC + TEST_XTRA - 1) : CW'(ACC_CYC - 1);
            end else if ((st == ST_ACCESS) && (acc_cnt != '0)) begin
                acc_cnt <= acc_cnt - 1'b1;
            end
            if (acc_done)
                rd_q <= test_mode ? {DW{rd_match}} : rd_word;
            if (wcbr_evt)
                test_mode <= 1'b1;
            else if (cbr_evt || ror_evt)
                test_mode <= 1'b0;
            if (wcbr_evt)      kind_q <= K_TEST;
            else if (cbr_evt)  kind_q <= K_CBR;
            else if (ror_evt)  kind_q <= K_ROR;
            else if (ew_evt)   kind_q <= K_EWRITE;
            else if (rd_start) kind_q <= K_READ;
            else if (rmw_evt)  kind_q <= K_RMW;
            else if (bad_evt)  kind_q <= K_ILLEGAL;
        end
    end

    // outputs
    always_comb begin
        mem_row     = row_q;
        mem_col     = (st == ST_ROW) ? addr[COL_W-1:0] : col_q;
        wr_en       = ew_evt || rmw_evt;
        wr_bcast    = test_mode;
        refresh_evt = cbr_evt || ror_evt;
        err         = (st == ST_BAD);
        dq_out      = (st == ST_BAD) ? BAD_MARK : rd_q;
        dq_oe       = !cas_n && !oe_n &&
                      ((st == ST_READ) || (st == ST_RMW) || (st == ST_BAD));
        cyc_kind    = kind_q;
    end

endmodule

// File: rtl/dramc_cycle_decoder.sv
module dramc_cycle_decoder #(
    parameter int            ROW_W       = 2,
    parameter int            COL_W       = 3,
    parameter int            DW          = 4,
    parameter int            CMP_W       = 2,
    parameter int            ACC_CYC     = 4,
    parameter int            TEST_XTRA   = 2,
    parameter int            STARTUP_CYC = 50000,
    parameter int            INIT_CYC    = 8,
    parameter logic [DW-1:0] BAD_MARK    = 4'hA,
    localparam int           AW          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          ready,
    output logic          test_mode,
    output logic          err,
    output logic [2:0]    cyc_kind
);
    logic [ROW_W-1:0] mem_row;
    logic [COL_W-1:0] mem_col;
    logic             wr_en, wr_bcast, refresh_evt, rd_match;
    logic [DW-1:0]    rd_word;

    dramc_init_tracker #(
        .STARTUP_CYC (STARTUP_CYC),
        .INIT_CYC    (INIT_CYC)
    ) u_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_evt (refresh_evt),
        .ready       (ready)
    );

    dramc_cell_array #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DW    (DW),
        .CMP_W (CMP_W)
    ) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_i    (mem_row),
        .col_i    (mem_col),
        .wr_en    (wr_en),
        .wr_bcast (wr_bcast),
        .wdata    (din),
        .rd_word  (rd_word),
        .rd_match (rd_match)
    );

    dramc_cycle_fsm #(
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .AW        (AW),
        .DW        (DW),
        .ACC_CYC   (ACC_CYC),
        .TEST_XTRA (TEST_XTRA),
        .BAD_MARK  (BAD_MARK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .addr        (addr),
        .ready       (ready),
        .rd_word     (rd_word),
        .rd_match    (rd_match),
        .mem_row     (mem_row),
        .mem_col     (mem_col),
        .wr_en       (wr_en),
        .wr_bcast    (wr_bcast),
        .refresh_evt (refresh_evt),
        .test_mode   (test_mode),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .err         (err),
        .cyc_kind    (cyc_kind)
    );

endmodule

// File: rtl/dramc_cycle_decoder_chk.sv
module dramc_cycle_decoder_chk #(
    parameter int            DW       = 4,
    parameter logic [DW-1:0] BAD_MARK = 4'hA
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          oe_n,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe,
    input logic          ready,
    input logic          test_mode,
    input logic          err,
    input logic [2:0]    cyc_kind
);
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_no_drive_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ready);

    p_drive_needs_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!oe_n && !cas_n));

    p_early_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(cas_n) && !cas_n && !we_n) |=> !dq_oe);

    p_test_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ras_n) && !ras_n && !cas_n && !we_n) |=> test_mode);

    p_test_exit_cbr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && $past(ras_n) && !ras_n && !cas_n && we_n) |=> !test_mode);

    p_test_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && dq_oe && !err) |-> (dq_out == '0 || dq_out == '1));

    p_err_marker_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cyc_kind == 3'd7 && dq_out == BAD_MARK));

endmodule

bind dramc_cycle_decoder dramc_cycle_decoder_chk #(
    .DW       (DW),
    .BAD_MARK (BAD_MARK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .ready     (ready),
    .test_mode (test_mode),
    .err       (err),
    .cyc_kind  (cyc_kind)
);

// File: tb/dramc_cycle_decoder_tb.sv
module dramc_cycle_decoder_tb;
    localparam int AW = 3;
    localparam int DW = 4;
    localparam int ACC = 4;
    localparam int TACC = 6;
    localparam int STARTUP = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, ready, test_mode, err;
    logic [2:0] cyc_kind;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dramc_cycle_decoder #(.STARTUP_CYC(STARTUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .ready(ready), .test_mode(test_mode), .err(err), .cyc_kind(cyc_kind)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_cycle();
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1;
        tick(2);
    endtask

    task automatic do_ror(logic [AW-1:0] r);
        addr = r; ras_n = 1'b0; tick(2);
        ras_n = 1'b1; tick(2);
    endtask

    task automatic do_cbr();
        cas_n = 1'b0; tick(1);
        ras_n = 1'b0; tick(2);
        end_cycle();
    endtask

    task automatic do_wcbr();
        cas_n = 1'b0; we_n = 1'b0; tick(1);
        ras_n = 1'b0; tick(2);
        end_cycle();
    endtask

    task automatic do_ewrite(logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] d, string req);
        addr = r; ras_n = 1'b0; tick(1);
        addr = c; din = d; we_n = 1'b0; oe_n = 1'b0; tick(1);
        cas_n = 1'b0; tick(1);
        chk(req, dq_oe, 1'b0);
        tick(ACC + 1);
        chk(req, dq_oe, 1'b0);
        end_cycle();
    endtask

    task automatic do_read(logic [AW-1:0] r, logic [AW-1:0] c, int lat,
                           logic [DW-1:0] exp, logic valid, string req);
        addr = r; ras_n = 1'b0; tick(1);
        addr = c; oe_n = 1'b0; cas_n = 1'b0; tick(lat);
        chk({req, " early"}, dq_oe, 1'b0);
        tick(1);
        chk({req, " oe"}, dq_oe, valid);
        if (valid) begin
            chk({req, " data"}, dq_out, exp);
            oe_n = 1'b1; #1;
            chk("R4 oe release", dq_oe, 1'b0);
        end
        end_cycle();
    endtask

    task automatic do_rmw(logic [AW-1:0] r, logic [AW-1:0] c, logic [DW-1:0] old_d,
                          logic [DW-1:0] new_d);
        addr = r; ras_n = 1'b0; tick(1);
        addr = c; oe_n = 1'b0; cas_n = 1'b0; tick(ACC + 1);
        chk("R6 read phase", dq_out, old_d);
        we_n = 1'b0; din = new_d; tick(1);
        chk("R6 kind", cyc_kind, 3'd3);
        chk("R6 still driving", dq_oe, 1'b1);
        chk("R6 old data held", dq_out, old_d);
        end_cycle();
    endtask

    task automatic do_illegal(logic [AW-1:0] r, logic [AW-1:0] c);
        addr = r; ras_n = 1'b0; tick(1);
        addr = c; oe_n = 1'b0; cas_n = 1'b0; tick(2);
        we_n = 1'b0; tick(1);
        chk("R12 err", err, 1'b1);
        chk("R12 kind", cyc_kind, 3'd7);
        chk("R12 oe", dq_oe, 1'b1);
        chk("R12 marker", dq_out, 4'hA);
        end_cycle();
        chk("R12 err clears", err, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(2);
        chk("R1 ready", ready, 1'b0);
        chk("R1 dq_oe", dq_oe, 1'b0);
        chk("R1 test_mode", test_mode, 1'b0);
        chk("R1 err", err, 1'b0);
        chk("R1 kind", cyc_kind, 3'd0);
        rst_n = 1'b1; tick(1);
        chk("R1 after release", {ready, dq_oe, test_mode, err}, 4'b0);

        // R3: accesses before ready are ignored
        do_ewrite(3'd0, 3'd0, 4'h5, "R3 write unready");
        chk("R3 kind unchanged", cyc_kind, 3'd0);
        do_read(3'd0, 3'd0, ACC, 4'h0, 1'b0, "R3 read unready");

        // R2: refreshes during start-up wait do not count
        do_cbr(); do_cbr(); do_cbr();
        chk("R2 early refresh", ready, 1'b0);
        tick(STARTUP);
        do_ror(3'd1); do_cbr(); do_ror(3'd2); do_cbr(); do_ror(3'd3); do_cbr(); do_ror(3'd0);
        chk("R2 seven refreshes", ready, 1'b0);
        do_ror(3'd1);
        chk("R2 eight refreshes", ready, 1'b1);
        chk("R7 row-only kind", cyc_kind, 3'd4);

        do_read(3'd0, 3'd0, ACC, 4'h0, 1'b1, "R3 ignored write left cell");
        chk("R4 kind", cyc_kind, 3'd1);

        do_ewrite(3'd2, 3'd3, 4'h9, "R5 early write hiz");
        chk("R5 kind", cyc_kind, 3'd2);
        do_read(3'd2, 3'd3, ACC, 4'h9, 1'b1, "R4 read");

        do_rmw(3'd2, 3'd3, 4'h9, 4'h6);
        do_read(3'd2, 3'd3, ACC, 4'h6, 1'b1, "R6 new data");

        do_cbr();
        chk("R7 cbr kind", cyc_kind, 3'd5);

        do_illegal(3'd2, 3'd3);

        do_wcbr();
        chk("R8 test set", test_mode, 1'b1);
        chk("R8 kind", cyc_kind, 3'd6);
        do_ewrite(3'd1, 3'd5, 4'h6, "R10 test write");
        chk("R8 test held", test_mode, 1'b1);
        do_read(3'd1, 3'd4, TACC, 4'hF, 1'b1, "R11 test read equal");

        do_ror(3'd0);
        chk("R9 row-only exit", test_mode, 1'b0);
        do_read(3'd1, 3'd7, ACC, 4'h6, 1'b1, "R10 group cell 7");
        do_read(3'd1, 3'd4, ACC, 4'h6, 1'b1, "R10 group cell 4");
        do_read(3'd1, 3'd3, ACC, 4'h0, 1'b1, "R10 outside group");

        do_ewrite(3'd1, 3'd6, 4'h2, "R5 normal write");
        do_wcbr();
        do_read(3'd1, 3'd4, TACC, 4'h0, 1'b1, "R11 test read differ");
        do_cbr();
        chk("R9 cbr exit", test_mode, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule